// File: doc/BRIEF.md
# 6-and-2 Sector Data Encoder

The encoder turns one 256-byte sector into the nibble stream of a disk data field. It reads the sector through a byte-wide read port, with the read data returned in the same cycle. It presents each output nibble on a byte output together with a one-cycle strobe. Strobes follow a fixed cadence of one nibble every `NIB_US` microseconds, and this interval is derived from the clock rate parameter. A serializer placed after the block shifts the nibbles to the head.

The field is built in this order:

- a self-sync lead-in and a three-byte prologue;
- 86 nibbles carrying the packed low two bits of every byte;
- 256 nibbles carrying the upper six bits of each byte;
- one checksum nibble;
- four closing marks.

Every six-bit value is XOR-chained with the value sent before it. The result is then mapped through a 64-entry table of valid disk bytes. Because of the chaining, the last value alone forms the checksum. If write protect is high when the operation starts, the block ends at once with an error and sends nothing.

Top module: `nib62_encoder`

## Requirements
- R1: After reset, `busy_o`, `nib_stb_o`, `done_o` and `err_o` are low.
- R2: A `start_i` pulse with `wprot_i` high while idle gives `done_o` and `err_o` high for one cycle in the next cycle. No strobe follows and `busy_o` stays low.
- R3: A started field opens with `SYNC_CNT` (default 5) nibbles of 0xFF, then 0xD5, 0xAA, 0xAD.
- R4: Group value k (k = 0..85) is a six-bit value. Bits 1:0 hold the bit-swapped low two bits of byte k. Bits 3:2 hold those of byte k+86. Bits 5:4 hold those of byte k+172, or zero when k ≥ 84. Groups are sent with k ascending. Each is sent as T(g[k] XOR g[k-1]), with g[-1] = 0.
- R5: Next come 256 nibbles for bytes 0 to 255 in ascending order. Each is T(byte[7:2] XOR previous six-bit value), and for byte 0 the previous value is g[85].
- R6: The checksum nibble is T(byte255[7:2]).
- R7: Four marks close the field: 0xDE, 0xAA, 0xEB, 0xFF.
- R8: T(v) is the v-th byte, in ascending order, from 0x80 to 0xFF that meets all three conditions: bit 7 set, at most one pair of adjacent zero bits, and at least one pair of adjacent one bits within bits 6..0. So T(0) = 0x96 and T(63) = 0xFF, and every nibble sent has bit 7 set.
- R9: Each strobe lasts one cycle. The first comes exactly PER = CLK_KHZ·NIB_US/1000 cycles after the start edge, and each later strobe exactly PER cycles after the one before.
- R10: `done_o` pulses with `err_o` low in the same cycle as the final mark's strobe. `busy_o` is low from the next cycle on.
- R11: `start_i` and `wprot_i` have no effect while `busy_o` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin one field when idle |
| wprot_i | input | 1 | Write protect, sampled with start |
| rd_addr_o | output | 8 | Sector buffer byte address |
| rd_data_i | input | 8 | Byte at `rd_addr_o`, same cycle |
| nib_o | output | 8 | Current disk nibble |
| nib_stb_o | output | 1 | One-cycle strobe for `nib_o` |
| busy_o | output | 1 | Field in progress |
| done_o | output | 1 | End-of-operation pulse |
| err_o | output | 1 | Error flag, valid with `done_o` |

## Verification
The assertions take two things for granted. First, the sector buffer answers `rd_addr_o` in the same cycle. Second, `PER` is at least 4, so each slot has time for its three byte reads before its strobe. The bench serves reads combinationally from an array that it changes only while the block is idle. The stimulus mixes all-zero, all-one, ascending and pseudo-random sectors, a write-protected start, and a start pulse with write protect high in the middle of a field. This keeps every case within those assumptions while still hitting the zero-masked top groups and the chain across section boundaries.

// File: rtl/nib62_pkg.sv
package nib62_pkg;

  typedef enum logic [2:0] {
    PH_IDLE, PH_SYNC, PH_PRO, PH_GRP, PH_DATA, PH_CSUM, PH_TAIL
  } phase_e;

  localparam int unsigned SECT_BYTES = 256;
  localparam int unsigned GRP_CNT    = (SECT_BYTES + 2) / 3;
  localparam int unsigned GRP_FULL   = SECT_BYTES - 2 * GRP_CNT;
  localparam int unsigned PRO_CNT    = 3;
  localparam int unsigned TAIL_CNT   = 4;
  localparam logic [7:0]  SYNC_NIB   = 8'hFF;

  function automatic logic [7:0] pro_nib(input logic [1:0] i);
    case (i)
      2'd0:    return 8'hD5;
      2'd1:    return 8'hAA;
      default: return 8'hAD;
    endcase
  endfunction

  function automatic logic [7:0] tail_nib(input logic [1:0] i);
    case (i)
      2'd0:    return 8'hDE;
      2'd1:    return 8'hAA;
      2'd2:    return 8'hEB;
      default: return 8'hFF;
    endcase
  endfunction

  // valid disk byte: msb set, <=1 adjacent zero pair, >=1 adjacent one pair below msb
  function automatic logic is_disk_byte(input logic [7:0] b);
    int  zp;
    logic op;
    zp = 0;
    op = 1'b0;
    for (int i = 0; i < 7; i++) if (!b[i] && !b[i+1]) zp++;
    for (int i = 0; i < 6; i++) if (b[i] && b[i+1]) op = 1'b1;
    return b[7] && (zp <= 1) && op;
  endfunction

  function automatic logic [511:0] build_xlat();
    logic [511:0] t;
    int n;
    t = '0;
    n = 0;
    for (int b = 128; b < 256; b++) begin
      if (is_disk_byte(8'(b)) && n < 64) begin
        t[n*8 +: 8] = 8'(b);
        n++;
      end
    end
    return t;
  endfunction

  localparam logic [511:0] XLAT_TAB = build_xlat();

  function automatic logic [7:0] xlat(input logic [5:0] v);
    return XLAT_TAB[{v, 3'b000} +: 8];
  endfunction

  function automatic logic [1:0] swap2(input logic [1:0] b);
    return {b[0], b[1]};
  endfunction

endpackage

// File: rtl/nib62_cadence.sv
module nib62_cadence #(
  parameter int unsigned PER   = 32,
  parameter int unsigned SUB_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  output logic [SUB_W-1:0] sub_o,
  output logic             tick_o
);

  localparam logic [SUB_W-1:0] LAST = SUB_W'(PER - 1);

  logic [SUB_W-1:0] cyc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cyc_q <= '0;
    else if (!run_i)         cyc_q <= '0;
    else if (cyc_q == LAST)  cyc_q <= '0;
    else                     cyc_q <= cyc_q + 1'b1;
  end

  assign sub_o  = cyc_q;
  assign tick_o = run_i && (cyc_q == LAST);

endmodule

// File: rtl/nib62_seq.sv
module nib62_seq
  import nib62_pkg::*;
#(
  parameter int unsigned SYNC_CNT = 5
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       wprot_i,
  input  logic       tick_i,
  output phase_e     phase_o,
  output logic [7:0] idx_o,
  output logic       done_o,
  output logic       err_o
);

  phase_e     phase_q;
  logic [7:0] idx_q;
  logic [7:0] last_idx;
  phase_e     next_phase;

  always_comb begin
    last_idx   = 8'd0;
    next_phase = PH_IDLE;
    unique case (phase_q)
      PH_SYNC: begin last_idx = 8'(SYNC_CNT - 1);   next_phase = PH_PRO;  end
      PH_PRO:  begin last_idx = 8'(PRO_CNT - 1);    next_phase = PH_GRP;  end
      PH_GRP:  begin last_idx = 8'(GRP_CNT - 1);    next_phase = PH_DATA; end
      PH_DATA: begin last_idx = 8'(SECT_BYTES - 1); next_phase = PH_CSUM; end
      PH_CSUM: begin last_idx = 8'd0;               next_phase = PH_TAIL; end
      PH_TAIL: begin last_idx = 8'(TAIL_CNT - 1);   next_phase = PH_IDLE; end
      default: begin last_idx = 8'd0;               next_phase = PH_IDLE; end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      idx_q   <= '0;
      done_o  <= 1'b0;
      err_o   <= 1'b0;
    end else begin
      done_o <= 1'b0;
      err_o  <= 1'b0;
      if (phase_q == PH_IDLE) begin
        if (start_i) begin
          if (wprot_i) begin
            done_o <= 1'b1;
            err_o  <= 1'b1;
          end else begin
            phase_q <= PH_SYNC;
            idx_q   <= '0;
          end
        end
      end else if (tick_i) begin
        if (idx_q == last_idx) begin
          idx_q   <= '0;
          phase_q <= next_phase;
          if (phase_q == PH_TAIL) done_o <= 1'b1;
        end else begin
          idx_q <= idx_q + 1'b1;
        end
      end
    end
  end

  assign phase_o = phase_q;
  assign idx_o   = idx_q;

endmodule

// File: rtl/nib62_fetch.sv
module nib62_fetch
  import nib62_pkg::*;
#(
  parameter int unsigned SUB_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  phase_e           phase_i,
  input  logic [7:0]       idx_i,
  input  logic [SUB_W-1:0] sub_i,
  input  logic [7:0]       rd_data_i,
  output logic [7:0]       rd_addr_o,
  output logic [5:0]       cur_o
);

  localparam logic [7:0] OFS_MID = 8'(GRP_CNT);
  localparam logic [7:0] OFS_TOP = 8'(2 * GRP_CNT);
  localparam logic [7:0] TOP_LIM = 8'(GRP_FULL);

  logic [7:0] b0_q;
  logic [1:0] b1_q, b2_q;
  logic       in_grp, in_data;

  assign in_grp  = (phase_i == PH_GRP);
  assign in_data = (phase_i == PH_DATA);

  always_comb begin
    rd_addr_o = 8'd0;
    if (in_grp) begin
      if (sub_i == SUB_W'(0))      rd_addr_o = idx_i;
      else if (sub_i == SUB_W'(1)) rd_addr_o = idx_i + OFS_MID;
      else                         rd_addr_o = idx_i + OFS_TOP;
    end else if (in_data) begin
      rd_addr_o = idx_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      b0_q <= '0;
      b1_q <= '0;
      b2_q <= '0;
    end else begin
      if ((in_grp || in_data) && sub_i == SUB_W'(0)) b0_q <= rd_data_i;
      if (in_grp && sub_i == SUB_W'(1))              b1_q <= rd_data_i[1:0];
      if (in_grp && sub_i == SUB_W'(2))              b2_q <= (idx_i < TOP_LIM) ? rd_data_i[1:0] : 2'b00;
    end
  end

  always_comb begin
    if (in_grp)       cur_o = {swap2(b2_q), swap2(b1_q), swap2(b0_q[1:0])};
    else if (in_data) cur_o = b0_q[7:2];
    else              cur_o = 6'd0;
  end

endmodule

// File: rtl/nib62_encoder.sv
module nib62_encoder
  import nib62_pkg::*;
#(
  parameter int unsigned CLK_KHZ  = 1000,
  parameter int unsigned NIB_US   = 32,
  parameter int unsigned SYNC_CNT = 5
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       wprot_i,
  output logic [7:0] rd_addr_o,
  input  logic [7:0] rd_data_i,
  output logic [7:0] nib_o,
  output logic       nib_stb_o,
  output logic       busy_o,
  output logic       done_o,
  output logic       err_o
);

  localparam int unsigned PER   = CLK_KHZ * NIB_US / 1000;
  localparam int unsigned SUB_W = (PER > 1) ? $clog2(PER) : 1;

  initial begin
    if (PER < 4) $error("nib62_encoder: PER must be at least 4");
  end

  phase_e           phase;
  logic [7:0]       idx;
  logic [SUB_W-1:0] sub;
  logic             tick;
  logic [5:0]       cur6;
  logic [5:0]       prev_q;
  logic [7:0]       nib_q;
  logic             stb_q;

  assign busy_o = (phase != PH_IDLE);

  nib62_cadence #(.PER(PER), .SUB_W(SUB_W)) u_cad (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_i (busy_o),
    .sub_o (sub),
    .tick_o(tick)
  );

  nib62_seq #(.SYNC_CNT(SYNC_CNT)) u_seq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start_i),
    .wprot_i(wprot_i),
    .tick_i (tick),
    .phase_o(phase),
    .idx_o  (idx),
    .done_o (done_o),
    .err_o  (err_o)
  );

  nib62_fetch #(.SUB_W(SUB_W)) u_fetch (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .phase_i  (phase),
    .idx_i    (idx),
    .sub_i    (sub),
    .rd_data_i(rd_data_i),
    .rd_addr_o(rd_addr_o),
    .cur_o    (cur6)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= '0;
      nib_q  <= '0;
      stb_q  <= 1'b0;
    end else begin
      stb_q <= 1'b0;
      if (phase == PH_IDLE) begin
        prev_q <= '0;
      end else if (tick) begin
        stb_q <= 1'b1;
        unique case (phase)
          PH_SYNC: nib_q <= SYNC_NIB;
          PH_PRO:  nib_q <= pro_nib(idx[1:0]);
          PH_GRP, PH_DATA: begin
            nib_q  <= xlat(cur6 ^ prev_q);
            prev_q <= cur6;
          end
          PH_CSUM: nib_q <= xlat(prev_q);
          PH_TAIL: nib_q <= tail_nib(idx[1:0]);
          default: nib_q <= nib_q;
        endcase
      end
    end
  end

  assign nib_o     = nib_q;
  assign nib_stb_o = stb_q;

endmodule

// File: rtl/nib62_encoder_chk.sv
module nib62_encoder_chk #(
  parameter int unsigned PER = 32
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       start_i,
  input logic       wprot_i,
  input logic       busy_o,
  input logic [7:0] nib_o,
  input logic       nib_stb_o,
  input logic       done_o,
  input logic       err_o
);

  logic [15:0] gap_q;
  logic        accept;

  assign accept = start_i && !busy_o && !wprot_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              gap_q <= '0;
    else if (accept)          gap_q <= '0;
    else if (nib_stb_o)       gap_q <= 16'd1;
    else if (gap_q != 16'hFFFF) gap_q <= gap_q + 1'b1;
  end

  // R9: strobe lands exactly PER cycles after start or previous strobe
  a_r9_stb_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nib_stb_o |-> gap_q == 16'(PER));

  a_r9_stb_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nib_stb_o |=> !nib_stb_o);

  a_r2_wprot_abort: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o && wprot_i) |=> (done_o && err_o && !busy_o));

  a_r2_err_needs_wprot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && err_o) |-> $past(wprot_i));

  a_r10_done_on_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !err_o) |-> (nib_stb_o && nib_o == 8'hFF));

  a_r10_idle_after_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !busy_o);

  a_r8_nib_msb: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nib_stb_o |-> nib_o[7]);

endmodule

bind nib62_encoder nib62_encoder_chk #(.PER(PER)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .start_i  (start_i),
  .wprot_i  (wprot_i),
  .busy_o   (busy_o),
  .nib_o    (nib_o),
  .nib_stb_o(nib_stb_o),
  .done_o   (done_o),
  .err_o    (err_o)
);

// File: tb/nib62_encoder_tb.sv
module nib62_encoder_tb;

  localparam int CLK_PERIOD = 10;
  localparam int PER        = 32;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic       wprot = 1'b0;
  logic [7:0] rd_addr, rd_data, nib;
  logic       stb, busy, done, err;
  logic [7:0] mem [256];

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int last_ev = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  localparam logic [7:0] TAB [64] = '{
    8'h96,8'h97,8'h9A,8'h9B,8'h9D,8'h9E,8'h9F,8'hA6,8'hA7,8'hAB,8'hAC,8'hAD,8'hAE,8'hAF,8'hB2,8'hB3,
    8'hB4,8'hB5,8'hB6,8'hB7,8'hB9,8'hBA,8'hBB,8'hBC,8'hBD,8'hBE,8'hBF,8'hCB,8'hCD,8'hCE,8'hCF,8'hD3,
    8'hD6,8'hD7,8'hD9,8'hDA,8'hDB,8'hDC,8'hDD,8'hDE,8'hDF,8'hE5,8'hE6,8'hE7,8'hE9,8'hEA,8'hEB,8'hEC,
    8'hED,8'hEE,8'hEF,8'hF2,8'hF3,8'hF4,8'hF5,8'hF6,8'hF7,8'hF9,8'hFA,8'hFB,8'hFC,8'hFD,8'hFE,8'hFF};

  assign rd_data = mem[rd_addr];

  nib62_encoder u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .wprot_i(wprot),
    .rd_addr_o(rd_addr), .rd_data_i(rd_data),
    .nib_o(nib), .nib_stb_o(stb), .busy_o(busy), .done_o(done), .err_o(err)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [1:0] sw(input logic [7:0] b);
    return {b[0], b[1]};
  endfunction

  task automatic push(input logic [7:0] v, input string tag);
    exp_q.push_back(v);
    tag_q.push_back(tag);
  endtask

  // expected field from the requirements
  task automatic build_expected();
    logic [5:0] g, prev, d;
    for (int s = 0; s < 5; s++) push(8'hFF, "R3");
    push(8'hD5, "R3"); push(8'hAA, "R3"); push(8'hAD, "R3");
    prev = 6'd0;
    for (int k = 0; k < 86; k++) begin
      g = {(k < 84) ? sw(mem[k+172]) : 2'b00, sw(mem[k+86]), sw(mem[k])};
      push(TAB[g ^ prev], "R4 R8");
      prev = g;
    end
    for (int m = 0; m < 256; m++) begin
      d = mem[m][7:2];
      push(TAB[d ^ prev], "R5 R8");
      prev = d;
    end
    push(TAB[prev], "R6");
    push(8'hDE, "R7"); push(8'hAA, "R7"); push(8'hEB, "R7"); push(8'hFF, "R7");
  endtask

  task automatic fill(input int kind);
    logic [7:0] lf = 8'h5B;
    for (int i = 0; i < 256; i++) begin
      case (kind)
        0: mem[i] = 8'h00;
        1: mem[i] = 8'hFF;
        2: mem[i] = 8'(i);
        default: begin
          lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
          mem[i] = lf ^ 8'(i * 7);
        end
      endcase
    end
  endtask

  // monitor: scoreboard pop and cadence check
  always @(negedge clk) begin
    if (rst_n && stb) begin
      check("R9 strobe interval", cyc - last_ev, PER);
      last_ev = cyc;
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R2/R10 unexpected nibble actual=%0h expected=none", nib);
      end else begin
        check(tag_q.pop_front(), nib, exp_q.pop_front());
      end
    end
  end

  task automatic run_field(input int kind, input bit glitch);
    fill(kind);
    build_expected();
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    last_ev = cyc;
    check("R11 busy after start", busy, 1);
    if (glitch) begin
      repeat (500) @(negedge clk);
      start = 1'b1; wprot = 1'b1;   // R11: must be ignored
      @(negedge clk);
      start = 1'b0; wprot = 1'b0;
    end
    while (!done) @(negedge clk);
    check("R10 err low at done", err, 0);
    check("R10 done with last strobe", stb, 1);
    @(negedge clk);
    check("R10 busy low after done", busy, 0);
    check("R10 R11 queue drained", exp_q.size(), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    fill(0);
    repeat (3) @(negedge clk);
    check("R1 busy", busy, 0);
    check("R1 strobe", stb, 0);
    check("R1 done", done, 0);
    check("R1 err", err, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 busy after release", busy, 0);

    // R2: protected start
    wprot = 1'b1; start = 1'b1;
    @(negedge clk);
    start = 1'b0; wprot = 1'b0;
    check("R2 done", done, 1);
    check("R2 err", err, 1);
    check("R2 busy", busy, 0);
    repeat (3 * PER) @(negedge clk);
    check("R2 no nibbles", exp_q.size(), 0);

    run_field(0, 1'b0);
    run_field(1, 1'b0);
    run_field(2, 1'b1);
    run_field(3, 1'b0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule